// File: doc/BRIEF.md
# Parallel-to-Serial Link Transmitter with Training Burst

This block turns a stream of 10-bit parallel words into a single serial bit stream, one 12-bit frame per word. Each frame opens with a 1 start bit, carries the word least significant bit first, and closes with a 0 stop bit. Words are taken from the parallel input on one edge of a word clock. The edge is chosen at run time. A bit-rate clock enable paces the shifter in the fast clock domain. Frames follow each other with no gap.

A link-training controller lets a receiver lock. Two request inputs are ORed. When the combined request has been seen high at enough consecutive word-capture strobes, the controller replaces payload data with a fixed-length burst of sync frames. The burst always runs to the end. The serial line is driven only when the output enable is high, power-down is low and reset has been released. A drive-enable flag shows when the line is driven and stands in for the high-impedance state.

Top module: `tx_serial_link`

## Requirements
- R1: Each frame is 12 bit-enable periods long. Bit 0 is a start bit of 1. Bits 1 to 10 carry the word, least significant bit first. Bit 11 is a stop bit of 0. The first frame after reset or power-down is loaded on the first active bit enable, and frames follow with no gap.
- R2: With `edge_sel`=0 the word is captured on the rising edge of `word_clk`. With `edge_sel`=1 it is captured on the falling edge.
- R3: While `bit_ce` is low the shifter holds its state, so `ser_out` stays constant.
- R4: The sync request is the OR of `sync_req_a` and `sync_req_b`. Either input alone can start a burst.
- R5: The request is sampled at each word-capture strobe. A burst starts only once the request has been high at 6 consecutive strobes. A low sample before that restarts the count, and no sync frame is sent.
- R6: A burst is exactly 1024 consecutive sync frames. Each one carries the word 10'b1111100000 (0x3E0) inside the normal start and stop bits.
- R7: Once a burst has started it completes even if the request drops.
- R8: If the request is still high when a burst ends, a fresh 6-strobe qualification runs. The two bursts are therefore separated by 5 or 6 data frames.
- R9: `drv_en` is 1 only while `out_en`=1, `pwr_dn`=0 and reset has been released. While `drv_en`=0, `ser_out` reads 0.
- R10: `pwr_dn`=1 aborts any burst, clears the qualification and restarts framing. After release, data frames resume without sync frames.
- R11: While reset is held, `drv_en`=0 and `ser_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_clk | input | 1 | Word clock, sampled in the clk domain |
| edge_sel | input | 1 | 0: capture on rising word_clk edge, 1: on falling edge |
| par_in | input | 10 | Parallel data word |
| bit_ce | input | 1 | Bit-rate clock enable for the shifter |
| sync_req_a | input | 1 | Sync request, first input |
| sync_req_b | input | 1 | Sync request, second input |
| out_en | input | 1 | Output enable |
| pwr_dn | input | 1 | Power-down, clears state and releases the line |
| ser_out | output | 1 | Serial bit stream |
| drv_en | output | 1 | Line driven flag (0 stands for high impedance) |

## Verification
The bench builds the block with its default parameters: 10-bit words, a 6-strobe qualification and a 1024-frame burst. The full burst length is therefore counted frame by frame as it would run in use. Two complete bursts, plus the gap forced by requalification while a request stays high, fit well inside the cycle budget because the word period is only 12 clocks. A bench-side frame decoder, aligned to reset and power-down, recovers every word. This lets sync runs, data gaps and framing errors be counted from the serial pin alone.

// File: rtl/tx_link_pkg.sv
package tx_link_pkg;

  // Which word-clock edge captures the parallel input
  typedef enum logic {
    CAP_RISE = 1'b0,
    CAP_FALL = 1'b1
  } cap_edge_e;

  localparam logic FRAME_START = 1'b1;
  localparam logic FRAME_STOP  = 1'b0;

endpackage

// File: rtl/tx_word_capture.sv
module tx_word_capture
  import tx_link_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_clk,
  input  logic              edge_sel,
  input  logic [DATA_W-1:0] par_in,
  output logic              word_stb,
  output logic [DATA_W-1:0] held_word
);

  logic              wclk_q;
  logic [DATA_W-1:0] hold_q, hold_n;
  logic              rise_hit, fall_hit, stb;

  always_comb begin
    rise_hit = word_clk & ~wclk_q;
    fall_hit = ~word_clk & wclk_q;
    stb      = (cap_edge_e'(edge_sel) == CAP_FALL) ? fall_hit : rise_hit;
    hold_n   = stb ? par_in : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q <= 1'b0;
      hold_q <= '0;
    end else begin
      wclk_q <= word_clk;
      hold_q <= hold_n;
    end
  end

  assign word_stb  = stb;
  assign held_word = hold_q;

endmodule

// File: rtl/tx_sync_ctrl.sv
module tx_sync_ctrl #(
  parameter int SYNC_QUAL = 6,
  parameter int BURST_LEN = 1024,
  localparam int QW = $clog2(SYNC_QUAL + 1),
  localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          word_stb,
  input  logic          req_a,
  input  logic          req_b,
  input  logic          frame_load,
  output logic          req_any,
  output logic          burst_act,
  output logic [QW-1:0] qual_cnt,
  output logic [BW-1:0] burst_cnt
);

  localparam logic [QW-1:0] QUAL_LAST  = QW'(SYNC_QUAL - 1);
  localparam logic [BW-1:0] BURST_LAST = BW'(BURST_LEN - 1);

  logic          act_q, act_n;
  logic [QW-1:0] qual_q, qual_n;
  logic [BW-1:0] cnt_q, cnt_n;
  logic          req;

  assign req = req_a | req_b;

  always_comb begin
    act_n  = act_q;
    qual_n = qual_q;
    cnt_n  = cnt_q;
    if (clr) begin
      act_n  = 1'b0;
      qual_n = '0;
      cnt_n  = '0;
    end else if (act_q) begin
      if (frame_load) begin
        if (cnt_q == BURST_LAST) begin
          act_n  = 1'b0;
          cnt_n  = '0;
          qual_n = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end else if (word_stb) begin
      if (req) begin
        if (qual_q == QUAL_LAST) begin
          act_n  = 1'b1;
          qual_n = '0;
        end else begin
          qual_n = qual_q + 1'b1;
        end
      end else begin
        qual_n = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      qual_q <= '0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_n;
      qual_q <= qual_n;
      cnt_q  <= cnt_n;
    end
  end

  assign req_any   = req;
  assign burst_act = act_q;
  assign qual_cnt  = qual_q;
  assign burst_cnt = cnt_q;

endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import tx_link_pkg::*;
#(
  parameter int              DATA_W    = 10,
  parameter logic [DATA_W-1:0] SYNC_WORD = 10'b1111100000,
  localparam int FRAME_W = DATA_W + 2,
  localparam int CW      = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_ce,
  input  logic [DATA_W-1:0] held_word,
  input  logic              use_sync,
  output logic              frame_load,
  output logic              ser_bit
);

  localparam logic [CW-1:0] BIT_LAST = CW'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q, sh_n;
  logic [CW-1:0]      bcnt_q, bcnt_n;
  logic [DATA_W-1:0]  word_src;
  logic [FRAME_W-1:0] load_vec;
  logic               load;

  assign word_src = use_sync ? SYNC_WORD : held_word;

  // Frame layout: start bit at position 0, payload LSB first, stop bit last
  assign load_vec[0]         = FRAME_START;
  assign load_vec[FRAME_W-1] = FRAME_STOP;
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_frame
    assign load_vec[gi+1] = word_src[gi];
  end

  always_comb begin
    load   = bit_ce && (bcnt_q == BIT_LAST) && !clr;
    sh_n   = sh_q;
    bcnt_n = bcnt_q;
    if (clr) begin
      sh_n   = '0;
      bcnt_n = BIT_LAST;
    end else if (bit_ce) begin
      if (bcnt_q == BIT_LAST) begin
        sh_n   = load_vec;
        bcnt_n = '0;
      end else begin
        sh_n   = {1'b0, sh_q[FRAME_W-1:1]};
        bcnt_n = bcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bcnt_q <= BIT_LAST;
    end else begin
      sh_q   <= sh_n;
      bcnt_q <= bcnt_n;
    end
  end

  assign frame_load = load;
  assign ser_bit    = sh_q[0];

endmodule

// File: rtl/tx_serial_link.sv
module tx_serial_link #(
  parameter int                DATA_W    = 10,
  parameter int                SYNC_QUAL = 6,
  parameter int                BURST_LEN = 1024,
  parameter logic [DATA_W-1:0] SYNC_WORD = 10'b1111100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_clk,
  input  logic              edge_sel,
  input  logic [DATA_W-1:0] par_in,
  input  logic              bit_ce,
  input  logic              sync_req_a,
  input  logic              sync_req_b,
  input  logic              out_en,
  input  logic              pwr_dn,
  output logic              ser_out,
  output logic              drv_en
);

  localparam int QW = $clog2(SYNC_QUAL + 1);
  localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

  logic              word_stb;
  logic [DATA_W-1:0] held_word;
  logic              frame_load;
  logic              ser_bit;
  logic              req_any;
  logic              burst_act;
  logic [QW-1:0]     qual_cnt;
  logic [BW-1:0]     burst_cnt;
  logic              live_q;
  logic              drive;

  tx_word_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_clk  (word_clk),
    .edge_sel  (edge_sel),
    .par_in    (par_in),
    .word_stb  (word_stb),
    .held_word (held_word)
  );

  tx_sync_ctrl #(.SYNC_QUAL(SYNC_QUAL), .BURST_LEN(BURST_LEN)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (pwr_dn),
    .word_stb   (word_stb),
    .req_a      (sync_req_a),
    .req_b      (sync_req_b),
    .frame_load (frame_load),
    .req_any    (req_any),
    .burst_act  (burst_act),
    .qual_cnt   (qual_cnt),
    .burst_cnt  (burst_cnt)
  );

  tx_frame_shifter #(.DATA_W(DATA_W), .SYNC_WORD(SYNC_WORD)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (pwr_dn),
    .bit_ce     (bit_ce),
    .held_word  (held_word),
    .use_sync   (burst_act),
    .frame_load (frame_load),
    .ser_bit    (ser_bit)
  );

  // Marks the first clock after reset release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;
  end

  assign drive   = live_q & out_en & ~pwr_dn;
  assign drv_en  = drive;
  assign ser_out = drive & ser_bit;

endmodule

// File: rtl/tx_serial_link_chk.sv
module tx_serial_link_chk #(
  parameter int SYNC_QUAL = 6,
  parameter int BURST_LEN = 1024,
  localparam int QW = $clog2(SYNC_QUAL + 1),
  localparam int BW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_ce,
  input logic          pwr_dn,
  input logic          word_stb,
  input logic          req_any,
  input logic          burst_act,
  input logic [QW-1:0] qual_cnt,
  input logic [BW-1:0] burst_cnt,
  input logic          frame_load,
  input logic          ser_bit
);

  assert_frame_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> ser_bit);

  assert_hold_no_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_ce && !pwr_dn) |=> $stable(ser_bit));

  assert_burst_after_qual_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_act) |-> $past(word_stb && req_any && (qual_cnt == QW'(SYNC_QUAL - 1))));

  assert_qual_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_cnt > $past(qual_cnt)) |-> $past(word_stb && req_any));

  assert_burst_idle_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_act |-> (burst_cnt == '0));

  assert_pwrdn_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (!burst_act && (qual_cnt == '0)));

endmodule

bind tx_serial_link tx_serial_link_chk #(
  .SYNC_QUAL (SYNC_QUAL),
  .BURST_LEN (BURST_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_ce     (bit_ce),
  .pwr_dn     (pwr_dn),
  .word_stb   (word_stb),
  .req_any    (req_any),
  .burst_act  (burst_act),
  .qual_cnt   (qual_cnt),
  .burst_cnt  (burst_cnt),
  .frame_load (frame_load),
  .ser_bit    (ser_bit)
);

// File: tb/sim_tx_serial_link.sv
module sim_tx_serial_link;

  localparam logic [9:0] SYNC = 10'h3E0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       word_clk = 1'b0;
  logic       edge_sel = 1'b0;
  logic [9:0] par_in = '0;
  logic       bit_ce = 1'b1;
  logic       sync_req_a = 1'b0;
  logic       sync_req_b = 1'b0;
  logic       out_en = 1'b1;
  logic       pwr_dn = 1'b0;
  logic       ser_out;
  logic       drv_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [9:0] rise_val = 10'h155;
  logic [9:0] fall_val = 10'h155;
  int wper = 0;

  // Frame decoder state
  logic [11:0] fr;
  int  idx = 0;
  bit  last_clr = 1'b1;
  bit  last_ce = 1'b0;
  logic [9:0] last_word = '0;
  bit  last_ok = 1'b0;
  int  nframes = 0, bad_frames = 0;
  int  sync_run = 0, sync_total = 0, last_run = 0, nbursts = 0;
  int  data_run = 0, last_gap = -1;

  tx_serial_link u0 (
    .clk(clk), .rst_n(rst_n), .word_clk(word_clk), .edge_sel(edge_sel),
    .par_in(par_in), .bit_ce(bit_ce), .sync_req_a(sync_req_a),
    .sync_req_b(sync_req_b), .out_en(out_en), .pwr_dn(pwr_dn),
    .ser_out(ser_out), .drv_en(drv_en)
  );

  always #5 clk = ~clk;

  // Word clock: 12 clk period, value rise_val presented at the rise, fall_val at the fall
  initial begin
    forever begin
      @(negedge clk);
      par_in = rise_val; word_clk = 1'b1; wper++;
      repeat (6) @(negedge clk);
      par_in = fall_val; word_clk = 1'b0;
      repeat (5) @(negedge clk);
    end
  end

  // Serial decoder, sampled 2 ns after the falling edge
  always begin
    @(negedge clk); #2;
    if (last_clr) idx = 0;
    else if (last_ce) begin
      fr[idx] = ser_out;
      idx++;
      if (idx == 12) begin
        idx = 0;
        last_ok = (fr[0] == 1'b1) && (fr[11] == 1'b0);
        last_word = fr[10:1];
        nframes++;
        if (!last_ok) bad_frames++;
        if (last_ok && last_word == SYNC) begin
          if (sync_run == 0) last_gap = data_run;
          sync_run++; sync_total++; data_run = 0;
        end else begin
          if (sync_run > 0) begin last_run = sync_run; nbursts++; end
          sync_run = 0; data_run++;
        end
      end
    end
    last_clr = !rst_n || pwr_dn;
    last_ce  = bit_ce;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_periods(input int n);
    repeat (n * 12) @(negedge clk);
  endtask

  // Wait for n rising word-clock strobes to pass, ending on a falling clk edge
  task automatic wait_rises(input int n);
    repeat (n) @(wper);
    @(negedge clk);
  endtask

  // {edge_sel, value at rise, value at fall}
  localparam int NV = 5;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 10'h001, 10'h2AA},
    {1'b1, 10'h001, 10'h2AA},
    {1'b0, 10'h200, 10'h0F0},
    {1'b1, 10'h133, 10'h200},
    {1'b0, 10'h155, 10'h155}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0, f0, s0;
    // R11 reset state
    repeat (3) @(negedge clk); #2;
    chk(drv_en == 1'b0, "R11", "drv_en in reset", drv_en, 0);
    chk(ser_out == 1'b0, "R11", "ser_out in reset", ser_out, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_periods(3);

    // R1 and R2 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [9:0] exp;
      edge_sel = VEC[i][20];
      rise_val = VEC[i][19:10];
      fall_val = VEC[i][9:0];
      exp = VEC[i][20] ? VEC[i][9:0] : VEC[i][19:10];
      wait_periods(3);
      f0 = nframes;
      wait_periods(4);
      chk(last_ok, "R1", "frame start/stop bits", last_ok, 1);
      chk(nframes - f0 == 4, "R1", "frames per 48 bit enables", nframes - f0, 4);
      chk(last_word == exp, "R2", "captured word", last_word, exp);
    end

    // R3 bit enable low holds the line
    begin
      logic v;
      @(negedge clk); bit_ce = 1'b0;
      #2 v = ser_out;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); #2;
        chk(ser_out == v, "R3", "ser_out held without bit_ce", ser_out, v);
      end
      @(negedge clk); bit_ce = 1'b1;
      wait_periods(4);
      chk(last_ok && last_word == 10'h155, "R3", "framing after stall", last_word, 10'h155);
    end

    // R5 five strobes do not qualify
    s0 = sync_total;
    wait_rises(1); sync_req_a = 1'b1;
    wait_rises(5); sync_req_a = 1'b0;
    wait_periods(10);
    chk(sync_total == s0, "R5", "sync frames after 5 strobes", sync_total - s0, 0);

    // R4, R6, R7: request on input b alone, dropped mid burst
    bad_frames = 0;
    n0 = nbursts;
    wait_rises(1); sync_req_b = 1'b1;
    wait_rises(8); sync_req_b = 1'b0;
    while (nbursts == n0) @(negedge clk);
    chk(last_run == 1024, "R6", "burst length", last_run, 1024);
    chk(last_run == 1024, "R7", "burst completes after drop", last_run, 1024);
    chk(n0 + 1 == nbursts, "R4", "burst from sync_req_b alone", nbursts - n0, 1);
    chk(bad_frames == 0, "R6", "sync frames framed", bad_frames, 0);
    wait_periods(2);
    chk(last_word == 10'h155, "R7", "data resumes", last_word, 10'h155);

    // R8, R4: request held on input a across burst end
    n0 = nbursts;
    wait_rises(1); sync_req_a = 1'b1;
    while (nbursts == n0) @(negedge clk);
    while (sync_run == 0) @(negedge clk);
    chk(last_gap >= 5 && last_gap <= 6, "R8", "data frames between bursts", last_gap, 5);
    sync_req_a = 1'b0;
    while (nbursts == n0 + 1) @(negedge clk);
    chk(last_run == 1024, "R8", "second burst length", last_run, 1024);
    chk(nbursts == n0 + 2, "R4", "bursts from sync_req_a", nbursts - n0, 2);

    // R10 power-down aborts a burst
    wait_rises(1); sync_req_a = 1'b1;
    wait_rises(6); sync_req_a = 1'b0;
    wait_periods(20);
    @(negedge clk); pwr_dn = 1'b1;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk); #2;
      if (k == 0 || k == 29) begin
        chk(drv_en == 1'b0, "R9", "drv_en in power-down", drv_en, 0);
        chk(ser_out == 1'b0, "R10", "line idle in power-down", ser_out, 0);
      end
    end
    @(negedge clk); pwr_dn = 1'b0;
    wait_periods(4);
    chk(last_run < 1024, "R10", "burst cut short", last_run, 1023);
    chk(sync_run == 0 && last_ok && last_word == 10'h155, "R10", "data after release",
        last_word, 10'h155);

    // R9 output enable
    @(negedge clk); out_en = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); #2;
      if (k == 0 || k == 19) begin
        chk(drv_en == 1'b0, "R9", "drv_en with out_en low", drv_en, 0);
        chk(ser_out == 1'b0, "R9", "ser_out with out_en low", ser_out, 0);
      end
    end
    @(negedge clk); out_en = 1'b1; #2;
    chk(drv_en == 1'b1, "R9", "drv_en restored", drv_en, 1);
    wait_periods(3);
    chk(last_ok && last_word == 10'h155, "R9", "frames after enable", last_word, 10'h155);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule